// File: doc/BRIEF.md
# Two-Port Contention Arbiter

This block sits in front of a memory array shared by two ports, called left and right. In every clock cycle it compares the chip enable and address of each port. It decides which port owns a location that both ports address at once. The port that loses is shown an active-low busy flag, and its write strobe toward the array is masked. The winner's strobe passes through unchanged. Reads are never blocked, because only the write strobe passes through this block.

Arrival order is resolved at cycle level. A port counts as "already there" when its enable was active at the previous clock edge with the same address it presents now. When both ports reach the same location in the same cycle, an alternating priority bit settles the tie. The tie goes to the port that lost the previous tie. The grant then stays with the winner for as long as both ports keep their enables and addresses.

A mode pin selects master or slave operation. In slave mode the block does no arbitration and drives its busy outputs inactive. It masks each port's write with a busy flag supplied by an external master. Several blocks can then act as one wider memory.

Top module: `dpa_contention_arbiter`

## Requirements
- R1: Contention exists only when both chip enables are high and the two addresses are equal. Otherwise, in master mode (master_mode=1), both busy outputs stay high.
- R2: On contention, a port whose enable was high with the same address at the previous clock edge beats a port that newly arrived. The newcomer's busy output goes low in the same cycle.
- R3: Busy is active low. It returns high in the cycle the addresses differ or either enable is low.
- R4: In master mode during contention, exactly one busy output is low.
- R5: When both ports arrive at a location in the same cycle, the tie goes to the port that lost the previous tie. After reset, the first tie goes to the left port.
- R6: Once a port has won, it keeps the grant for as long as both enables stay high and neither address changes, even if the tie priority now favours the other port.
- R7: A port's write output equals its write request while its busy flag is high, and is forced low while that flag is low.
- R8: In slave mode (master_mode=0), both busy outputs are held high and no arbitration takes place. Each write output is the write request ANDed with that port's busy input (active low).
- R9: A synchronous active-high reset holds both busy outputs high, clears the arrival history and sets the tie priority to the left port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = take busy from outside |
| l_ce | input | 1 | Left chip enable, active high |
| l_addr | input | ADDR_W | Left address |
| l_wr | input | 1 | Left write request |
| l_busy_in_n | input | 1 | Left busy from external master (slave mode) |
| r_ce | input | 1 | Right chip enable, active high |
| r_addr | input | ADDR_W | Right address |
| r_wr | input | 1 | Right write request |
| r_busy_in_n | input | 1 | Right busy from external master (slave mode) |
| l_busy_out_n | output | 1 | Left busy flag, active low |
| r_busy_out_n | output | 1 | Right busy flag, active low |
| l_wr_out | output | 1 | Gated left write strobe to the array |
| r_wr_out | output | 1 | Gated right write strobe to the array |

## Verification
The bench targets the case where the winner must keep the grant right after a tie, while the priority bit already favours the other side. A design without the hold would hand the location over in mid-access. It also covers a late arrival against a held port in both directions; a design that ignores history would decide by fixed priority and pick the wrong loser. Two ties are separated by a non-tie win to show that only ties flip the priority. A reset during contention must release busy and return the next tie to the left port. In slave mode, a busy input that is ignored would let a blocked write through, and an arbiter left running would pull a busy output low.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NUM_PORTS = 2;
  localparam int LEFT_IDX  = 0;
  localparam int RIGHT_IDX = 1;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              stay
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce;
      addr_q <= addr;
    end
  end

  // Port was already present at this location at the last edge
  assign stay = ce & ce_q & (addr == addr_q);
endmodule

// File: rtl/dpa_arb_core.sv
module dpa_arb_core
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              ce_l,
  input  logic              ce_r,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              stay_l,
  input  logic              stay_r,
  output logic              win_l,
  output logic              win_r
);
  owner_e owner_q, owner_d;
  logic   prio_q;   // 0: left takes next tie, 1: right
  logic   tie;
  logic   match;

  assign match = master & ce_l & ce_r & (addr_l == addr_r);

  always_comb begin
    owner_d = OWN_NONE;
    tie     = 1'b0;
    if (match) begin
      if (owner_q != OWN_NONE && stay_l && stay_r) begin
        owner_d = owner_q;
      end else if (stay_l && !stay_r) begin
        owner_d = OWN_LEFT;
      end else if (stay_r && !stay_l) begin
        owner_d = OWN_RIGHT;
      end else begin
        tie     = 1'b1;
        owner_d = prio_q ? OWN_RIGHT : OWN_LEFT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= OWN_NONE;
      prio_q  <= 1'b0;
    end else begin
      owner_q <= owner_d;
      if (tie) prio_q <= (owner_d == OWN_LEFT);
    end
  end

  assign win_l = (owner_d == OWN_LEFT);
  assign win_r = (owner_d == OWN_RIGHT);

  // R5
  tie_flips_prio_chk: assert property (@(posedge clk) disable iff (rst)
    tie |=> (prio_q != $past(prio_q)));

  // R9
  reset_prio_left_chk: assert property (@(posedge clk)
    rst |=> (prio_q == 1'b0 && owner_q == OWN_NONE));
endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
  input  logic rst,
  input  logic master,
  input  logic lost,
  input  logic busy_in_n,
  input  logic wr_req,
  output logic busy_out_n,
  output logic wr_out
);
  logic blocked;

  assign busy_out_n = ~(master & ~rst & lost);
  assign blocked    = master ? ~busy_out_n : ~busy_in_n;
  assign wr_out     = wr_req & ~blocked;
endmodule

// File: rtl/dpa_contention_arbiter.sv
module dpa_contention_arbiter
  import dpa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic              l_busy_in_n,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic              r_busy_in_n,
  output logic              l_busy_out_n,
  output logic              r_busy_out_n,
  output logic              l_wr_out,
  output logic              r_wr_out
);
  logic              ce_v   [NUM_PORTS];
  logic [ADDR_W-1:0] addr_v [NUM_PORTS];
  logic              wr_v   [NUM_PORTS];
  logic              bin_v  [NUM_PORTS];
  logic              stay_v [NUM_PORTS];
  logic              win_v  [NUM_PORTS];
  logic              bout_v [NUM_PORTS];
  logic              wout_v [NUM_PORTS];

  assign ce_v[LEFT_IDX]    = l_ce;
  assign ce_v[RIGHT_IDX]   = r_ce;
  assign addr_v[LEFT_IDX]  = l_addr;
  assign addr_v[RIGHT_IDX] = r_addr;
  assign wr_v[LEFT_IDX]    = l_wr;
  assign wr_v[RIGHT_IDX]   = r_wr;
  assign bin_v[LEFT_IDX]   = l_busy_in_n;
  assign bin_v[RIGHT_IDX]  = r_busy_in_n;

  dpa_arb_core #(.ADDR_W(ADDR_W)) core_i (
    .clk    (clk),
    .rst    (rst),
    .master (master_mode),
    .ce_l   (l_ce),
    .ce_r   (r_ce),
    .addr_l (l_addr),
    .addr_r (r_addr),
    .stay_l (stay_v[LEFT_IDX]),
    .stay_r (stay_v[RIGHT_IDX]),
    .win_l  (win_v[LEFT_IDX]),
    .win_r  (win_v[RIGHT_IDX])
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpa_port_track #(.ADDR_W(ADDR_W)) track_i (
      .clk  (clk),
      .rst  (rst),
      .ce   (ce_v[p]),
      .addr (addr_v[p]),
      .stay (stay_v[p])
    );
    dpa_port_gate gate_i (
      .rst        (rst),
      .master     (master_mode),
      .lost       (win_v[NUM_PORTS-1-p]),
      .busy_in_n  (bin_v[p]),
      .wr_req     (wr_v[p]),
      .busy_out_n (bout_v[p]),
      .wr_out     (wout_v[p])
    );
  end

  assign l_busy_out_n = bout_v[LEFT_IDX];
  assign r_busy_out_n = bout_v[RIGHT_IDX];
  assign l_wr_out     = wout_v[LEFT_IDX];
  assign r_wr_out     = wout_v[RIGHT_IDX];

  logic hit;
  assign hit = l_ce & r_ce & (l_addr == r_addr);

  // R1
  no_false_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (l_busy_out_n && r_busy_out_n));

  // R4
  one_loser_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && hit) |-> ($countones({~l_busy_out_n, ~r_busy_out_n}) == 1));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && hit && $past(hit) &&
     $stable(l_addr) && $stable(r_addr) && $past(!r_busy_out_n))
    |-> !r_busy_out_n);

  // R7
  loser_write_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && (!l_busy_out_n || !r_busy_out_n)) |->
      (!(l_wr_out && !l_busy_out_n) && !(r_wr_out && !r_busy_out_n)));

  // R8
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !master_mode |-> (l_busy_out_n && r_busy_out_n &&
                      (l_wr_out == (l_wr && l_busy_in_n)) &&
                      (r_wr_out == (r_wr && r_busy_in_n))));

  // R9
  reset_release_chk: assert property (@(posedge clk)
    rst |-> (l_busy_out_n && r_busy_out_n));
endmodule

// File: tb/dpa_contention_arbiter_tb.sv
module dpa_contention_arbiter_tb_top;
  localparam int AW = 8;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          master_mode = 1'b1;
  logic          l_ce = 1'b0, r_ce = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic          l_busy_out_n, r_busy_out_n, l_wr_out, r_wr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dpa_contention_arbiter #(.ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .master_mode  (master_mode),
    .l_ce         (l_ce),
    .l_addr       (l_addr),
    .l_wr         (l_wr),
    .l_busy_in_n  (l_busy_in_n),
    .r_ce         (r_ce),
    .r_addr       (r_addr),
    .r_wr         (r_wr),
    .r_busy_in_n  (r_busy_in_n),
    .l_busy_out_n (l_busy_out_n),
    .r_busy_out_n (r_busy_out_n),
    .l_wr_out     (l_wr_out),
    .r_wr_out     (r_wr_out)
  );

  // {l_ce, l_addr, l_wr, r_ce, r_addr, r_wr, master, l_bin, r_bin,
  //  exp {l_busy, r_busy, l_wr_out, r_wr_out}}
  localparam logic [26:0] TBL [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1100}, // R1 idle
    {1'b1, 8'h05, 1'b1, 1'b1, 8'h06, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1111}, // R1 no match
    {1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010}, // R2 left first
    {1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010}, // R6 hold
    {1'b0, 8'h05, 1'b0, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1101}, // R3 ce drop
    {1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0101}, // R2 right first
    {1'b1, 8'h09, 1'b1, 1'b1, 8'h09, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010}, // R5 tie -> left
    {1'b1, 8'h09, 1'b1, 1'b1, 8'h09, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010}, // R6 hold past prio
    {1'b0, 8'h09, 1'b0, 1'b0, 8'h09, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1100}, // R3 both off
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0101}, // R5 tie -> right
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0B, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1111}, // R3 mismatch
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010}, // R2 right returns late
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1101}, // R8 slave left blocked
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1110}, // R8 slave right blocked
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b0, 1'b1, 1'b1, 4'b1111}, // R8 slave no arbitration
    {1'b1, 8'h0A, 1'b1, 1'b1, 8'h0A, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1010}  // R5 R7 tie -> left
  };
  localparam string TAG [NV] = '{"R1", "R1", "R2", "R6", "R3", "R2", "R5", "R6",
                                 "R3", "R5", "R3", "R2", "R8", "R8", "R8", "R5"};

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {l_busy_out_n, r_busy_out_n, l_wr_out, r_wr_out};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {l_busy,r_busy,l_wr,r_wr} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [26:0] v);
    {l_ce, l_addr, l_wr, r_ce, r_addr, r_wr, master_mode, l_busy_in_n, r_busy_in_n} = v[26:4];
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R9", 4'b1100); // reset state
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      #2;
      check(TAG[i], TBL[i][3:0]);
      @(negedge clk);
    end
    // R5: drop both, then arrive together; priority now favours right
    l_ce = 1'b0; r_ce = 1'b0; l_wr = 1'b0; r_wr = 1'b0;
    @(negedge clk);
    l_ce = 1'b1; r_ce = 1'b1; l_addr = 8'h20; r_addr = 8'h20; l_wr = 1'b1; r_wr = 1'b1;
    #2;
    check("R5", 4'b0101);
    // R9: reset during contention releases busy
    @(negedge clk) rst = 1'b1;
    @(negedge clk); #2;
    check("R9", 4'b1111);
    // R9: after reset the tie goes to the left port
    @(negedge clk) rst = 1'b0;
    #2;
    check("R9", 4'b1010);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule